// File: doc/BRIEF.md
# UTMI Link-Side Packet Interface

This block sits on the controller side of an 8-bit UTMI+ connection to a USB 2.0 transceiver and runs on the transceiver's 60 MHz clock. It turns a byte-stream source into transmit packets on the transceiver bus. The first byte of each packet is the PID. Bytes are paced by the transceiver's ready handshake. The block can end a packet early by switching the operating mode to the no-encoding setting while the transmit request is still high. That makes the transceiver close the packet as a bad one.

On the receive side it collects the bytes that the transceiver marks valid inside an active window. It skips the slots where the valid qualifier drops, and hands the bytes on as a byte stream with a last marker. Any error reported inside the window is carried on the final beat. Transmit waits while the receiver is active, and the block leaves one idle cycle after every transmit packet. CRC, bit stuffing, line coding and all analog behaviour belong to the transceiver.

Top module: `utmi_link_if`

## Requirements
- R1: After reset, utmiTxValid is 0, utmiOpMode is 2'b00, txsReady is 0 and rxsValid is 0.
- R2: A packet starts only when the transmitter is idle, utmiRxActive is low and txsValid is high. In the cycle after that edge, utmiTxValid is 1 and utmiDataOut carries that first byte (the PID).
- R3: A transmit byte is consumed only at an edge where utmiTxValid and utmiTxReady are both 1. Otherwise utmiDataOut keeps its value. After a consumption the next source byte appears on utmiDataOut one cycle later.
- R4: In the cycle after the byte flagged txsLast is consumed, utmiTxValid is 0. utmiOpMode returns to 2'b00 one cycle later, and no new packet can start in that gap cycle.
- R5: If txsRaw is 1 together with the first byte, utmiOpMode is 2'b10 (no SYNC/EOP) for the whole packet. Otherwise it is 2'b00.
- R6: If txsAbort is high during a packet, or the source has no byte when the transceiver takes a non-last byte, then utmiOpMode becomes 2'b10 while utmiTxValid stays 1 for one more cycle. After that utmiTxValid drops, and the mode is unchanged in the cycle it drops.
- R7: A receive byte is accepted only at an edge where utmiRxActive and utmiRxValid are both 1. Bytes come out on rxsData in order, each as a one-cycle rxsValid pulse in the cycle after the next byte is accepted or after utmiRxActive is sampled low.
- R8: The final byte of a receive packet carries rxsLast=1, and all earlier bytes carry rxsLast=0.
- R9: If utmiRxError is sampled high while utmiRxActive is high, rxsErr is 1 on the final beat. A packet with an error and no bytes yields one beat with rxsData=8'h00, rxsLast=1 and rxsErr=1. rxsErr is 0 on every other beat.
- R10: txsReady is high only in a cycle where the presented byte is loaded, and never without txsValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver clock |
| rstN | input | 1 | Active-low synchronous reset |
| txsData | input | 8 | Transmit source byte |
| txsValid | input | 1 | Transmit source byte present |
| txsLast | input | 1 | Byte is the final one of the packet |
| txsRaw | input | 1 | Send packet without SYNC/EOP (sampled with first byte) |
| txsAbort | input | 1 | Abandon the packet in flight |
| txsReady | output | 1 | Source byte taken this cycle |
| rxsData | output | 8 | Received byte |
| rxsValid | output | 1 | Received beat present (one cycle) |
| rxsLast | output | 1 | Beat ends the packet |
| rxsErr | output | 1 | Packet had a receive error |
| utmiDataOut | output | 8 | Transmit byte to transceiver |
| utmiTxValid | output | 1 | Transmit request |
| utmiTxReady | input | 1 | Transceiver took the byte |
| utmiOpMode | output | 2 | Operating mode: 00 normal, 10 no SYNC/EOP |
| utmiDataIn | input | 8 | Receive byte from transceiver |
| utmiRxActive | input | 1 | Receive window open |
| utmiRxValid | input | 1 | Receive byte valid |
| utmiRxError | input | 1 | Receive error |

## Verification
A transmit request can arrive in the same cycle as a receive window. The bench provokes this by queuing a packet on the source while it drives an active receive sequence that contains a dropped-valid slot and an error. The bench model then expects the transmit start to be held off until utmiRxActive is sampled low. On every clock it compares both streams with a behavioural model. In the same cycle it also compares txsReady and the transceiver-side outputs, so a start that leaks into the receive window shows up as a mismatch on utmiTxValid and txsReady.

// File: rtl/utmi_link_pkg.sv
package utmi_link_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_ABORT = 2'd2,
    TX_GAP   = 2'd3
  } txState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic txStart;    // raise transmit request
    logic txLoad;     // capture source byte into bus register
    logic txStop;     // drop transmit request
    logic opRaw;      // mode for the starting packet is raw
    logic opAbort;    // force no-encoding mode mid packet
    logic opClear;    // return to normal mode
    logic rxTake;     // capture receive byte into holding register
    logic rxEmitMid;  // emit held byte as a non-final beat
    logic rxEmitEnd;  // emit final beat
    logic rxEndData;  // final beat carries the held byte
    logic rxEndErr;   // final beat flags an error
  } strobes_t;

  localparam logic [1:0] OPM_NORMAL = 2'b00;
  localparam logic [1:0] OPM_RAW    = 2'b10;

endpackage

// File: rtl/utmi_link_ctrl.sv
module utmi_link_ctrl
  import utmi_link_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txsValid,
  input  logic     txsLast,
  input  logic     txsRaw,
  input  logic     txsAbort,
  output logic     txsReady,
  input  logic     utmiTxReady,
  input  logic     utmiRxActive,
  input  logic     utmiRxValid,
  input  logic     utmiRxError,
  output strobes_t strb
);

  txState_t state, stateNext;
  logic lastReg;
  logic pendValid;
  logic inPkt;
  logic errSticky;

  always_comb begin
    strb      = '0;
    txsReady  = 1'b0;
    stateNext = state;
    unique case (state)
      TX_IDLE: begin
        if (txsValid && !utmiRxActive) begin
          txsReady      = 1'b1;
          strb.txStart  = 1'b1;
          strb.txLoad   = 1'b1;
          strb.opRaw    = txsRaw;
          stateNext     = TX_SEND;
        end
      end
      TX_SEND: begin
        if (txsAbort) begin
          strb.opAbort = 1'b1;
          stateNext    = TX_ABORT;
        end else if (utmiTxReady) begin
          if (lastReg) begin
            strb.txStop = 1'b1;
            stateNext   = TX_GAP;
          end else if (txsValid) begin
            txsReady    = 1'b1;
            strb.txLoad = 1'b1;
          end else begin
            strb.opAbort = 1'b1;
            stateNext    = TX_ABORT;
          end
        end
      end
      TX_ABORT: begin
        strb.txStop = 1'b1;
        stateNext   = TX_GAP;
      end
      TX_GAP: begin
        strb.opClear = 1'b1;
        stateNext    = TX_IDLE;
      end
      default: stateNext = TX_IDLE;
    endcase

    strb.rxTake    = utmiRxActive && utmiRxValid;
    strb.rxEmitMid = strb.rxTake && pendValid;
    strb.rxEmitEnd = inPkt && !utmiRxActive && (pendValid || errSticky);
    strb.rxEndData = pendValid;
    strb.rxEndErr  = errSticky;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= TX_IDLE;
      lastReg   <= 1'b0;
      pendValid <= 1'b0;
      inPkt     <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.txLoad) lastReg <= txsLast;
      inPkt     <= utmiRxActive;
      pendValid <= utmiRxActive ? (pendValid || strb.rxTake) : 1'b0;
      errSticky <= utmiRxActive ? (errSticky || utmiRxError) : 1'b0;
    end
  end

  // R10: the source is only ever acknowledged with a byte present
  a_r10_ready_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    txsReady |-> txsValid);

endmodule

// File: rtl/utmi_link_dp.sv
module utmi_link_dp
  import utmi_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] txsData,
  input  logic [DATA_W-1:0] utmiDataIn,
  output logic [DATA_W-1:0] utmiDataOut,
  output logic              utmiTxValid,
  output logic [1:0]        utmiOpMode,
  output logic [DATA_W-1:0] rxsData,
  output logic              rxsValid,
  output logic              rxsLast,
  output logic              rxsErr
);

  logic [DATA_W-1:0] pendData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      utmiDataOut <= '0;
      utmiTxValid <= 1'b0;
      utmiOpMode  <= OPM_NORMAL;
    end else begin
      if (strb.txLoad) utmiDataOut <= txsData;
      if (strb.txStart)     utmiTxValid <= 1'b1;
      else if (strb.txStop) utmiTxValid <= 1'b0;
      if (strb.txStart)      utmiOpMode <= strb.opRaw ? OPM_RAW : OPM_NORMAL;
      else if (strb.opAbort) utmiOpMode <= OPM_RAW;
      else if (strb.opClear) utmiOpMode <= OPM_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendData <= '0;
      rxsData  <= '0;
      rxsValid <= 1'b0;
      rxsLast  <= 1'b0;
      rxsErr   <= 1'b0;
    end else begin
      if (strb.rxTake) pendData <= utmiDataIn;
      rxsValid <= strb.rxEmitMid || strb.rxEmitEnd;
      rxsLast  <= strb.rxEmitEnd;
      rxsErr   <= strb.rxEmitEnd && strb.rxEndErr;
      if (strb.rxEmitMid)
        rxsData <= pendData;
      else if (strb.rxEmitEnd)
        rxsData <= strb.rxEndData ? pendData : '0;
    end
  end

  // R9: an error is only reported on a final beat
  a_r9_err_on_last: assert property (@(posedge clk) disable iff (!rstN)
    rxsErr |-> (rxsValid && rxsLast));

endmodule

// File: rtl/utmi_link_if.sv
module utmi_link_if
  import utmi_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txsData,
  input  logic              txsValid,
  input  logic              txsLast,
  input  logic              txsRaw,
  input  logic              txsAbort,
  output logic              txsReady,
  output logic [DATA_W-1:0] rxsData,
  output logic              rxsValid,
  output logic              rxsLast,
  output logic              rxsErr,
  output logic [DATA_W-1:0] utmiDataOut,
  output logic              utmiTxValid,
  input  logic              utmiTxReady,
  output logic [1:0]        utmiOpMode,
  input  logic [DATA_W-1:0] utmiDataIn,
  input  logic              utmiRxActive,
  input  logic              utmiRxValid,
  input  logic              utmiRxError
);

  strobes_t strb;

  utmi_link_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .txsValid     (txsValid),
    .txsLast      (txsLast),
    .txsRaw       (txsRaw),
    .txsAbort     (txsAbort),
    .txsReady     (txsReady),
    .utmiTxReady  (utmiTxReady),
    .utmiRxActive (utmiRxActive),
    .utmiRxValid  (utmiRxValid),
    .utmiRxError  (utmiRxError),
    .strb         (strb)
  );

  utmi_link_dp #(.DATA_W(DATA_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .txsData     (txsData),
    .utmiDataIn  (utmiDataIn),
    .utmiDataOut (utmiDataOut),
    .utmiTxValid (utmiTxValid),
    .utmiOpMode  (utmiOpMode),
    .rxsData     (rxsData),
    .rxsValid    (rxsValid),
    .rxsLast     (rxsLast),
    .rxsErr      (rxsErr)
  );

  // R2: a transmit request never rises out of an active receive window
  a_r2_no_start_in_rx: assert property (@(posedge clk) disable iff (!rstN)
    $rose(utmiTxValid) |-> !$past(utmiRxActive));

  // R3: a byte not taken by the transceiver stays on the bus
  a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rstN)
    (utmiTxValid && !utmiTxReady) |=> $stable(utmiDataOut));

  // R6: the mode does not change in the cycle the request is dropped
  a_r6_mode_at_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(utmiTxValid) |-> $stable(utmiOpMode));

endmodule

// File: tb/test_utmi_link_if.sv
module test_utmi_link_if;

  typedef struct { logic [7:0] d; bit l; bit r; } srcEnt_t;
  typedef struct { bit a; bit v; bit e; logic [7:0] d; } rxEnt_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] txsData = '0, utmiDataIn = '0;
  logic txsValid = 0, txsLast = 0, txsRaw = 0, txsAbort = 0;
  logic utmiTxReady = 0, utmiRxActive = 0, utmiRxValid = 0, utmiRxError = 0;
  logic txsReady, rxsValid, rxsLast, rxsErr, utmiTxValid;
  logic [7:0] rxsData, utmiDataOut;
  logic [1:0] utmiOpMode;

  utmi_link_if i_utmi_link_if (
    .clk(clk), .rstN(rstN),
    .txsData(txsData), .txsValid(txsValid), .txsLast(txsLast),
    .txsRaw(txsRaw), .txsAbort(txsAbort), .txsReady(txsReady),
    .rxsData(rxsData), .rxsValid(rxsValid), .rxsLast(rxsLast), .rxsErr(rxsErr),
    .utmiDataOut(utmiDataOut), .utmiTxValid(utmiTxValid), .utmiTxReady(utmiTxReady),
    .utmiOpMode(utmiOpMode), .utmiDataIn(utmiDataIn), .utmiRxActive(utmiRxActive),
    .utmiRxValid(utmiRxValid), .utmiRxError(utmiRxError)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  srcEnt_t srcQ[$];
  rxEnt_t  rxQ[$];
  logic [7:0] pendQ[$];

  // reference model state
  int  mPh = 0;          // 0 idle, 1 sending, 2 aborting, 3 gap
  bit  mVal = 0, mLast = 0, mInPk = 0, mErr = 0;
  logic [7:0] mData = 0;
  logic [1:0] mOp = 2'b00;
  bit  eRv = 0, eRl = 0, eRe = 0;
  logic [7:0] eRd = 0;
  int  sentCnt = 0;
  bit  abortArm = 0;
  int  readyMode = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic oneCycle();
    bit eRdy;
    @(negedge clk);
    cyc++;
    // registered outputs against the model
    chk(utmiTxValid == mVal, (mPh == 3) ? "R4 txValid" : "R2 txValid", utmiTxValid, mVal);
    if (mVal) chk(utmiDataOut == mData, "R3 data", utmiDataOut, mData);
    chk(utmiOpMode == mOp, (mPh >= 2) ? "R6 opMode" : "R5 opMode", utmiOpMode, mOp);
    chk(rxsValid == eRv, "R7 rxValid", rxsValid, eRv);
    if (eRv) begin
      chk(rxsData == eRd, "R7 rxData", rxsData, eRd);
      chk(rxsLast == eRl, "R8 rxLast", rxsLast, eRl);
      chk(rxsErr == eRe, "R9 rxErr", rxsErr, eRe);
    end
    // drive inputs for the coming edge
    txsValid = srcQ.size() > 0;
    txsData  = txsValid ? srcQ[0].d : 8'h00;
    txsLast  = txsValid ? srcQ[0].l : 1'b0;
    txsRaw   = txsValid ? srcQ[0].r : 1'b0;
    txsAbort = abortArm && (mPh == 1) && (sentCnt >= 2);
    utmiTxReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (rxQ.size() > 0) begin
      rxEnt_t e = rxQ.pop_front();
      utmiRxActive = e.a; utmiRxValid = e.v; utmiRxError = e.e; utmiDataIn = e.d;
    end else begin
      utmiRxActive = 0; utmiRxValid = 0; utmiRxError = 0; utmiDataIn = 8'h00;
    end
    #1;
    eRdy = (mPh == 0 && txsValid && !utmiRxActive) ||
           (mPh == 1 && !txsAbort && utmiTxReady && !mLast && txsValid);
    chk(txsReady == eRdy, "R10 txsReady", txsReady, eRdy);
    // advance transmit model
    case (mPh)
      0: if (eRdy) begin
           mVal = 1; mData = txsData; mLast = txsLast; mOp = txsRaw ? 2'b10 : 2'b00; mPh = 1;
         end
      1: if (txsAbort) begin
           mOp = 2'b10; mPh = 2;
         end else if (utmiTxReady) begin
           if (mLast) begin mVal = 0; mPh = 3; end
           else if (txsValid) begin mData = txsData; mLast = txsLast; end
           else begin mOp = 2'b10; mPh = 2; end
         end
      2: begin mVal = 0; mPh = 3; end
      default: begin mOp = 2'b00; mPh = 0; end
    endcase
    if (eRdy) begin
      void'(srcQ.pop_front());
      sentCnt = (mPh == 1 && txsValid && utmiDataOut !== 8'hxx) ? sentCnt + 1 : sentCnt + 1;
    end
    if (txsAbort) begin srcQ.delete(); abortArm = 0; end
    // advance receive model
    eRv = 0; eRl = 0; eRe = 0;
    if (utmiRxActive) begin
      mInPk = 1;
      mErr = mErr | utmiRxError;
      if (utmiRxValid) begin
        if (pendQ.size() > 0) begin eRv = 1; eRd = pendQ.pop_front(); end
        pendQ.push_back(utmiDataIn);
      end
    end else if (mInPk) begin
      mInPk = 0;
      if (pendQ.size() > 0) begin eRv = 1; eRl = 1; eRe = mErr; eRd = pendQ.pop_front(); end
      else if (mErr) begin eRv = 1; eRl = 1; eRe = 1; eRd = 8'h00; end
      mErr = 0;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) oneCycle();
  endtask

  task automatic pushRx(input bit a, input bit v, input bit e, input logic [7:0] d);
    rxEnt_t x; x.a = a; x.v = v; x.e = e; x.d = d; rxQ.push_back(x);
  endtask

  task automatic pushTx(input logic [7:0] d, input bit l, input bit r);
    srcEnt_t x; x.d = d; x.l = l; x.r = r; srcQ.push_back(x);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(utmiTxValid == 0, "R1 txValid", utmiTxValid, 0);
    chk(utmiOpMode == 2'b00, "R1 opMode", utmiOpMode, 0);
    chk(rxsValid == 0, "R1 rxValid", rxsValid, 0);
    chk(txsReady == 0, "R1 txsReady", txsReady, 0);
    rstN = 1'b1;

    // R2: start-of-frame packet with transceiver always ready
    pushTx(8'hA5, 0, 0); pushTx(8'h3C, 0, 0); pushTx(8'h81, 1, 0);
    run(10);

    // R3: transceiver stalls on some cycles
    readyMode = 1;
    pushTx(8'hC3, 0, 0); pushTx(8'h01, 0, 0); pushTx(8'h02, 0, 0); pushTx(8'h03, 1, 0);
    run(16);

    // R4: two back-to-back packets, gap cycle between them
    readyMode = 0;
    pushTx(8'hD2, 1, 0); pushTx(8'h4B, 1, 0);
    run(10);

    // R5: raw packet
    pushTx(8'hF0, 0, 1); pushTx(8'h0F, 1, 1);
    run(10);

    // R6: explicit abort after two bytes
    abortArm = 1; sentCnt = 0;
    pushTx(8'h69, 0, 0); pushTx(8'h11, 0, 0); pushTx(8'h22, 0, 0);
    pushTx(8'h33, 0, 0); pushTx(8'h44, 1, 0);
    run(12);

    // R6: underrun of the source mid packet
    pushTx(8'hE1, 0, 0); pushTx(8'h55, 0, 0);
    run(10);

    // R7 R8 R9: receive with a dropped-valid slot and an error,
    // while a transmit request waits for the window to close
    pushRx(1, 0, 0, 8'h00); pushRx(1, 1, 0, 8'h11); pushRx(1, 1, 0, 8'h22);
    pushRx(1, 0, 0, 8'h99); pushRx(1, 1, 1, 8'h33); pushRx(0, 0, 0, 8'h00);
    pushTx(8'h5A, 0, 0); pushTx(8'h77, 1, 0);
    run(16);

    // R9: error-only receive packet
    pushRx(1, 0, 0, 8'h00); pushRx(1, 0, 1, 8'h00); pushRx(0, 0, 0, 8'h00);
    run(6);

    // R8: single-byte receive packet without error
    pushRx(1, 1, 0, 8'hB4); pushRx(0, 0, 0, 8'h00);
    run(6);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule